// File: doc/BRIEF.md
# Memory Fill Engine

This block writes one repeated pattern over a range of memory, in the manner of a hardware memset. Software sets a start address, an end address and a 32-bit pattern value through a register port with four word slots. It then writes the control word with its go bit set. The engine walks the range one 64-bit word at a time on a valid/ready write port. When the range is covered it raises a finished flag, a level interrupt and a one-cycle interrupt pulse.

Addresses are word addresses in units of 8 bytes, so the region is always 8-byte aligned. The pattern can be 16, 24 or 32 bits wide. A 24-bit pattern does not fit a 64-bit word evenly, so its byte phase carries across word boundaries. If software writes the go bit again while a fill is running, the running fill is dropped and a new one starts from the current register contents. A chip may hold several instances side by side, and each instance is independent.

Top module: `fill_engine`

## Requirements
- R1: The register slot is chosen by `reg_idx_i`: 0 is the start address, 1 is the end address, 2 is the pattern value and 3 is control. Start and end read back the written value masked to ADDR_W bits. Control reads bit0 as busy, bit1 as finished and bits 9:8 as the width code last written, with all other bits zero.
- R2: A control write with bit0 = 1 makes the busy bit read 1 and the finished bit read 0 from the next cycle on. In that same next cycle the write port offers the start address, if start is less than end.
- R3: The port offers word addresses from start up to end-1 in increasing order. It advances by one only on a cycle where valid and ready are both high, and valid is never high while busy reads 0.
- R4: If end is less than or equal to start, the fill finishes with no accepted write. Busy reads 1 for exactly one cycle before finished is set.
- R5: After the last word is accepted, valid drops. One cycle later busy clears, finished sets, `irq_o` rises and `irq_pulse_o` is high for exactly one cycle.
- R6: While valid is high and ready is low, address, data and valid hold steady unless a new start is written.
- R7: Width code 0 puts value[15:0] in each 16-bit lane of the word. Width code 2 puts value[31:0] in both 32-bit halves.
- R8: Width codes 1 and 3 select the 24-bit pattern. Let n be the word's distance from the start address. Byte j of that word (j = 0 is the least significant byte) holds pattern byte (8n + j) mod 3, where pattern bytes 0, 1 and 2 are value[7:0], value[15:8] and value[23:16].
- R9: A start written while busy drops the running fill without a completion pulse. It restarts from the start register with the pattern phase reset, so exactly one completion follows.
- R10: A control write with bit1 = 1 and bit0 = 0 clears finished and `irq_o`, unless a fill completes in that same cycle. A control write with bit1 = 0 leaves finished unchanged.
- R11: Writes to the start, end and value registers during a fill do not change the running fill. Those values are captured when the fill starts.
- R12: After reset all registers read 0, valid is low and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register slot (byte offset / 4) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of slot `reg_idx_i` |
| mem_addr_o | output | ADDR_W | 64-bit word address of the current write |
| mem_data_o | output | 64 | Write data |
| mem_valid_o | output | 1 | Write request |
| mem_ready_i | input | 1 | Write accepted when high with valid |
| irq_o | output | 1 | Level interrupt, follows finished |
| irq_pulse_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a restart that lands while a word is stalled with ready low, after software has already rewritten the start, end and value registers behind the running fill. The bench drives ready from a pseudo-random sequence. Partway through a long fill it rewrites those three registers and then retriggers. A behavioural model checks every cycle that the old fill goes on unchanged until the restart and that only one completion follows. Back-to-back runs with empty and inverted ranges, together with clear writes around completion, cover the edges of the finished flag.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    FW_16  = 2'd0,
    FW_24A = 2'd1,
    FW_32  = 2'd2,
    FW_24B = 2'd3
  } fill_w_e;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_VALUE = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fill_regs.sv
module fill_regs
  import fill_pkg::*;
#(
  parameter int unsigned ADDR_W = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        idx_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [31:0]       rdata_o,
  output logic              start_o,
  output logic              clear_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [ADDR_W-1:0] end_addr_o,
  output logic [31:0]       value_o,
  output fill_w_e           start_width_o
);
  reg_sel_e sel;
  logic [ADDR_W-1:0] start_q, end_q;
  logic [31:0] value_q;
  fill_w_e width_q;

  assign sel = reg_sel_e'(idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      value_q <= '0;
      width_q <= FW_16;
    end else if (we_i) begin
      unique case (sel)
        SEL_START: start_q <= wdata_i[ADDR_W-1:0];
        SEL_END:   end_q   <= wdata_i[ADDR_W-1:0];
        SEL_VALUE: value_q <= wdata_i;
        SEL_CTRL:  width_q <= fill_w_e'(wdata_i[9:8]);
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_START: rdata_o = 32'(start_q);
      SEL_END:   rdata_o = 32'(end_q);
      SEL_VALUE: rdata_o = value_q;
      SEL_CTRL:  rdata_o = {22'd0, width_q, 6'd0, done_i, busy_i};
    endcase
  end

  assign start_o       = we_i && (sel == SEL_CTRL) && wdata_i[0];
  assign clear_o       = we_i && (sel == SEL_CTRL) && wdata_i[1];
  assign start_addr_o  = start_q;
  assign end_addr_o    = end_q;
  assign value_o       = value_q;
  assign start_width_o = fill_w_e'(wdata_i[9:8]);
endmodule

// File: rtl/fill_pattern.sv
module fill_pattern
  import fill_pkg::*;
(
  input  logic [31:0]       value_i,
  input  fill_w_e           width_i,
  input  logic [1:0]        phase_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [1:0] tri_sel;
    logic [7:0] lane_b;
    always_comb begin
      tri_sel = 2'((32'(phase_i) + 32'(j)) % 32'd3);
      unique case (width_i)
        FW_16:   lane_b = value_i[8*(j%2) +: 8];
        FW_32:   lane_b = value_i[8*(j%4) +: 8];
        default: begin
          unique case (tri_sel)
            2'd0:    lane_b = value_i[7:0];
            2'd1:    lane_b = value_i[15:8];
            default: lane_b = value_i[23:16];
          endcase
        end
      endcase
    end
    assign data_o[8*j +: 8] = lane_b;
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int unsigned ADDR_W = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [31:0]       value_i,
  input  fill_w_e           width_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       run_value_o,
  output fill_w_e           run_width_o,
  output logic [1:0]        phase_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_pulse_o
);
  logic busy_q, done_q, pulse_q, more, finishing;
  logic [ADDR_W-1:0] cur_q, end_q;
  logic [31:0] val_q;
  fill_w_e wid_q;
  logic [1:0] phase_q;

  assign more      = cur_q < end_q;
  assign finishing = busy_q && !more;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
      cur_q   <= '0;
      end_q   <= '0;
      val_q   <= '0;
      wid_q   <= FW_16;
      phase_q <= 2'd0;
    end else begin
      pulse_q <= 1'b0;
      if (start_i) begin
        // retrigger drops any running fill
        busy_q  <= 1'b1;
        done_q  <= 1'b0;
        cur_q   <= start_addr_i;
        end_q   <= end_addr_i;
        val_q   <= value_i;
        wid_q   <= width_i;
        phase_q <= 2'd0;
      end else begin
        if (finishing) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          pulse_q <= 1'b1;
        end else begin
          if (clear_i) done_q <= 1'b0;
          if (busy_q && mem_ready_i) begin
            cur_q   <= cur_q + 1'b1;
            // 8 bytes advance the 3-byte phase by 2
            phase_q <= (phase_q == 2'd0) ? 2'd2 : phase_q - 2'd1;
          end
        end
      end
    end
  end

  assign mem_valid_o = busy_q && more;
  assign mem_addr_o  = cur_q;
  assign run_value_o = val_q;
  assign run_width_o = wid_q;
  assign phase_o     = phase_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign irq_pulse_o = pulse_q;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && !done_o);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i && !start_i) |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i && !start_i) |=> (mem_valid_o && $stable(mem_addr_o)));
  p_pulse_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |=> !irq_pulse_o);
  p_pulse_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> (done_o && !busy_o));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !start_i && !busy_o) |=> !done_o);
endmodule

// File: rtl/fill_engine.sv
module fill_engine
  import fill_pkg::*;
#(
  parameter int unsigned ADDR_W = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_data_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              irq_o,
  output logic              irq_pulse_o
);
  logic start, clear, busy, done;
  logic [ADDR_W-1:0] start_addr, end_addr;
  logic [31:0] value, run_value;
  fill_w_e start_width, run_width;
  logic [1:0] phase;

  fill_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .idx_i(reg_idx_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .done_i(done), .rdata_o(reg_rdata_o),
    .start_o(start), .clear_o(clear),
    .start_addr_o(start_addr), .end_addr_o(end_addr),
    .value_o(value), .start_width_o(start_width)
  );

  fill_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .clear_i(clear),
    .start_addr_i(start_addr), .end_addr_i(end_addr),
    .value_i(value), .width_i(start_width),
    .mem_ready_i, .mem_valid_o, .mem_addr_o,
    .run_value_o(run_value), .run_width_o(run_width), .phase_o(phase),
    .busy_o(busy), .done_o(done), .irq_pulse_o
  );

  fill_pattern u_pat (
    .value_i(run_value), .width_i(run_width), .phase_i(phase), .data_o(mem_data_o)
  );

  assign irq_o = done;

  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i && !start) |=> $stable(mem_data_o));
  p_irq_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> irq_o);
endmodule

// File: tb/tb_fill_engine.sv
module tb_fill_engine;
  localparam int AW = 29;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic we = 1'b0;
  logic [1:0] idx = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic [AW-1:0] maddr;
  logic [63:0] mdata;
  logic mvalid, mready = 1'b1, irq, irq_p;

  fill_engine #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mem_addr_o(maddr), .mem_data_o(mdata), .mem_valid_o(mvalid),
    .mem_ready_i(mready), .irq_o(irq), .irq_pulse_o(irq_p)
  );

  int total = 0, bad = 0, hs = 0, pulses = 0, cyc = 0;
  bit rmode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  logic [AW-1:0] r_start = '0, r_end = '0, m_cur = '0, m_end = '0;
  logic [31:0] r_val = '0, m_val = '0;
  logic [1:0] m_w = '0;
  bit m_busy = 0, m_done = 0, m_pulse = 0;
  int m_n = 0;

  function automatic logic [63:0] exp_word(logic [31:0] v, logic [1:0] w, int n);
    logic [63:0] r;
    for (int j = 0; j < 8; j++) begin
      int b;
      if (w == 2'd0) b = j % 2;
      else if (w == 2'd2) b = j % 4;
      else b = (8 * n + j) % 3;
      r[8*j +: 8] = v[8*b +: 8];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    bit fin;
    fin = m_busy && !(m_cur < m_end);
    if (mvalid && mready) hs++;
    m_pulse = 0;
    if (we && idx == 2'd3 && wdata[0]) begin
      m_busy = 1; m_done = 0; m_cur = r_start; m_end = r_end;
      m_val = r_val; m_w = wdata[9:8]; m_n = 0;
    end else if (fin) begin
      m_busy = 0; m_done = 1; m_pulse = 1;
    end else begin
      if (we && idx == 2'd3 && wdata[1]) m_done = 0;
      if (m_busy && mready) begin m_cur = m_cur + 1'b1; m_n++; end
    end
    if (we) begin
      case (idx)
        2'd0: r_start = wdata[AW-1:0];
        2'd1: r_end = wdata[AW-1:0];
        2'd2: r_val = wdata;
        default: ;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit ev;
    ev = m_busy && (m_cur < m_end);
    chk("R3 valid", 64'(mvalid), 64'(ev));
    if (ev) begin
      chk("R3/R6 addr", 64'(maddr), 64'(m_cur));
      chk(m_w[0] ? "R8 data" : "R7 data", mdata, exp_word(m_val, m_w, m_n));
    end
    chk("R5 pulse", 64'(irq_p), 64'(m_pulse));
    chk("R10 irq", 64'(irq), 64'(m_done));
    if (irq_p) pulses++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mready <= rmode ? lfsr[0] : 1'b1;
  end

  task automatic wr(logic [1:0] i, logic [31:0] d);
    we = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] i, logic [31:0] exp, string tag);
    idx = i; #1;
    chk(tag, 64'(rdata), 64'(exp));
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int h0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    rd(0, 0, "R12 start"); rd(1, 0, "R12 end"); rd(2, 0, "R12 value"); rd(3, 0, "R12 ctrl");
    chk("R12 valid", 64'(mvalid), 0);
    chk("R12 irq", 64'({irq, irq_p}), 0);

    // R1 register map
    wr(0, 32'h100); wr(1, 32'h105); wr(2, 32'hA1B2C3D4); wr(3, 32'h300);
    rd(0, 32'h100, "R1 start"); rd(1, 32'h105, "R1 end");
    rd(2, 32'hA1B2C3D4, "R1 value"); rd(3, 32'h300, "R1 ctrl");
    wr(0, 32'hFFFF_FFF8); rd(0, 32'h1FFF_FFF8, "R1 mask");
    wr(0, 32'h100);

    // R2, R3, R7 16-bit fill, ready always high
    h0 = hs; p0 = pulses;
    wr(3, 32'h001);
    rd(3, 32'h001, "R2 busy");
    wait_idle();
    chk("R3 count", 64'(hs - h0), 5);
    rd(3, 32'h002, "R5 done");
    chk("R5 pulses", 64'(pulses - p0), 1);

    // R10 clear behaviour
    wr(3, 32'h000); rd(3, 32'h002, "R10 keep");
    wr(3, 32'h002); rd(3, 32'h000, "R10 clear");
    chk("R10 irq low", 64'(irq), 0);

    // R7 32-bit with random ready (R6 stalls)
    rmode = 1'b1;
    h0 = hs;
    wr(0, 32'h400); wr(1, 32'h40C); wr(2, 32'h13579BDF); wr(3, 32'h201);
    wait_idle();
    chk("R7 count", 64'(hs - h0), 12);

    // R8 24-bit, codes 1 and 3
    h0 = hs;
    wr(0, 32'h201); wr(1, 32'h20A); wr(2, 32'h00C0FFEE); wr(3, 32'h101);
    wait_idle();
    chk("R8 count", 64'(hs - h0), 9);
    wr(0, 32'h50); wr(1, 32'h57); wr(3, 32'h301);
    wait_idle();

    // R4 empty and inverted ranges
    h0 = hs;
    wr(1, 32'h50); wr(0, 32'h50); wr(3, 32'h003);
    wait_idle();
    chk("R4 equal", 64'(hs - h0), 0);
    rd(3, 32'h002, "R4 done");
    wr(0, 32'h60); wr(3, 32'h103);
    wait_idle();
    chk("R4 inverted", 64'(hs - h0), 0);
    rd(3, 32'h102, "R4 done2");

    // R11 rewrite during fill, R9 retrigger
    p0 = pulses;
    wr(0, 32'h800); wr(1, 32'h840); wr(2, 32'h11112222); wr(3, 32'h101);
    repeat (3) @(negedge clk);
    wr(2, 32'hDEADBEEF); wr(0, 32'h900); wr(1, 32'h903);
    repeat (4) @(negedge clk);
    rd(3, 32'h101, "R11 still busy");
    wr(3, 32'h001);
    wait_idle();
    chk("R9 one completion", 64'(pulses - p0), 1);
    rd(0, 32'h900, "R11 regs");

    finish_run();
  end
endmodule